// File: doc/BRIEF.md
# Debug Reset Hold Controller

This block holds a debugger-owned control word and turns its bits into the reset and halt controls of a processor subsystem. The debugger can ask the core to halt, force the whole system into reset for as long as it likes, and keep the core alone in reset once reset sequencing has finished. It can also arm a hold that takes effect on the next return from a deep low-leakage stop mode. The block sees register writes, a secure-mode flag, a level that says reset sequencing is finished, pulses for deep-stop entry and exit, the wake-through-reset-pin flag, and the recovery power-on reset level. Its outputs are the halt request, the system reset hold, the core reset hold and a one-cycle pulse that clears the sticky low-power status flags held elsewhere.

Two state machines carry the timed behaviour. The low-power sequencer (`drh_lp_seq`) has five states: RUN, STOP, EXIT, POR and HOLD. RUN goes to STOP on an entry pulse and captures the arm bit at that moment. STOP goes back to RUN on an exit pulse if the capture was 0 or the wake came through the reset pin. Otherwise STOP goes to EXIT. EXIT goes to POR when the recovery power-on reset rises. POR goes to HOLD when that reset falls. HOLD goes to RUN on the first cycle in which the acknowledge bit reads 1. The system is held in reset in EXIT, POR and HOLD.

The core-hold machine (`drh_core_hold`) has three states: SEQ, RUN and HELD. SEQ goes to RUN when sequencing finishes with the hold-config bit clear, and to HELD when it finishes with that bit set. HELD goes to RUN once the bit is clear. RUN and HELD both go back to SEQ whenever sequencing restarts.

Top module: `dbg_rst_hold_ctrl`

## Requirements
- R1: After rst_n is released, rd_data is 0 and halt_req, sys_rst_hold, core_rst_hold and stat_clr are all low.
- R2: halt_req equals control bit 2, starting in the cycle after the write that changes it.
- R3: sys_rst_hold is high in every cycle in which control bit 3 reads 1.
- R4: If seq_done is sampled high while the core-hold machine is in SEQ, it moves at that edge to HELD when bit 4 is 1 (core_rst_hold goes high) or to RUN when bit 4 is 0 (core_rst_hold stays low).
- R5: core_rst_hold drops in the same cycle in which bit 4 first reads 0, with no extra state step.
- R6: The arm bit (bit 5) is captured on the lp_enter pulse. Later writes to bit 5 do not change what happens at the following exit.
- R7: After an armed exit without a pin wake, sys_rst_hold stays high until the recovery power-on reset has risen and fallen. It then stays high until the cycle after the first cycle in which bit 6 reads 1.
- R8: When wake_pin is high on the exit pulse, no hold follows, even if bit 5 was captured as 1.
- R9: While lp_por is high, bits 5 and 6 clear at every edge, and this takes priority over a write in the same cycle.
- R10: stat_clr is a one-cycle pulse in the cycle after bit 7 changes from 0 to 1. Rewriting 1 to a bit 7 that is already set gives no pulse.
- R11: While secure is high, a write changes only bit 3, and bits 2, 4, 5, 6 and 7 keep their values.
- R12: Bits 0, 1 and 8 to 31 always read 0, and writes to them are dropped.
- R13: An acknowledge bit that is already 1 before the recovery power-on reset does not release the hold during EXIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the always-on logic |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| secure | input | 1 | Secure mode; only bit 3 is writable |
| rd_data | output | 32 | Current control word |
| seq_done | input | 1 | High when system reset sequencing is finished |
| lp_enter | input | 1 | One-cycle pulse on deep-stop entry |
| lp_exit | input | 1 | One-cycle pulse on deep-stop exit |
| wake_pin | input | 1 | Exit was caused by the reset pin (sampled with lp_exit) |
| lp_por | input | 1 | Recovery power-on reset level |
| halt_req | output | 1 | Core halt request |
| sys_rst_hold | output | 1 | Hold the system in reset |
| core_rst_hold | output | 1 | Hold the core in reset |
| stat_clr | output | 1 | One-cycle clear of the sticky low-power status flags |

## Verification
The bench plants an acknowledge before the recovery reset. A design that ignores the EXIT/POR ordering would let the system out of reset early. It checks that the hold survives the first cycle in which the acknowledge reads 1 and drops one cycle later, which catches an off-by-one in the release. Changing the arm bit while stopped, and waking through the pin, expose designs that read bit 5 live or ignore the pin flag. Clearing bit 4 while the core is held, rewriting a set bit 7, and writing while lp_por is high catch a registered core release, a level-sensitive status clear, and a write that beats the reset clear.

// File: rtl/drh_pkg.sv
package drh_pkg;
    localparam int REG_W   = 32;
    localparam int B_HALT  = 2;
    localparam int B_SRST  = 3;
    localparam int B_CHOLD = 4;
    localparam int B_ARM   = 5;
    localparam int B_ACK   = 6;
    localparam int B_STACK = 7;

    typedef enum logic [2:0] {
        SQ_RUN,
        SQ_STOP,
        SQ_EXIT,
        SQ_POR,
        SQ_HOLD
    } sq_state_t;

    typedef enum logic [1:0] {
        CH_SEQ,
        CH_RUN,
        CH_HELD
    } ch_state_t;
endpackage

// File: rtl/drh_ctl_reg.sv
module drh_ctl_reg
    import drh_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         secure,
    input  logic         lp_por,
    output logic [W-1:0] ctl_q,
    output logic         stat_clr
);
    localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SEC_MASK  = ONE << B_SRST;
    localparam logic [W-1:0] IMPL_MASK = (ONE << B_HALT) | (ONE << B_SRST) |
                                         (ONE << B_CHOLD) | (ONE << B_ARM) |
                                         (ONE << B_ACK) | (ONE << B_STACK);

    logic [W-1:0] ctl_d;
    logic [W-1:0] wmask;
    logic         stack_prev_q;

    always_comb begin
        wmask = secure ? SEC_MASK : IMPL_MASK;
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = (ctl_q & ~wmask) | (wr_data & wmask);
        end
        if (lp_por) begin
            ctl_d[B_ARM] = 1'b0;
            ctl_d[B_ACK] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            stack_prev_q <= 1'b0;
        end else begin
            ctl_q        <= ctl_d;
            stack_prev_q <= ctl_q[B_STACK];
        end
    end

    always_comb begin
        stat_clr = ctl_q[B_STACK] & ~stack_prev_q;
    end

    // R11
    secure_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && secure) |=> (ctl_q[B_HALT] == $past(ctl_q[B_HALT]) &&
                               ctl_q[B_CHOLD] == $past(ctl_q[B_CHOLD]) &&
                               ctl_q[B_STACK] == $past(ctl_q[B_STACK])));
    // R9
    por_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_por |=> (!ctl_q[B_ARM] && !ctl_q[B_ACK]));
    // R10
    stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !stat_clr);
    // R12
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/drh_lp_seq.sv
module drh_lp_seq
    import drh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_enter,
    input  logic lp_exit,
    input  logic wake_pin,
    input  logic lp_por,
    input  logic arm_bit,
    input  logic ack_bit,
    output logic sys_hold
);
    sq_state_t state_q, state_d;
    logic      cap_q, cap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_RUN;
            cap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cap_q   <= cap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cap_d   = cap_q;
        unique case (state_q)
            SQ_RUN: begin
                if (lp_enter) begin
                    state_d = SQ_STOP;
                    cap_d   = arm_bit;
                end
            end
            SQ_STOP: begin
                if (lp_exit) begin
                    state_d = (cap_q && !wake_pin) ? SQ_EXIT : SQ_RUN;
                    cap_d   = 1'b0;
                end
            end
            SQ_EXIT: begin
                if (lp_por) state_d = SQ_POR;
            end
            SQ_POR: begin
                if (!lp_por) state_d = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (ack_bit) state_d = SQ_RUN;
            end
            default: state_d = SQ_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SQ_EXIT, SQ_POR, SQ_HOLD: sys_hold = 1'b1;
            default:                  sys_hold = 1'b0;
        endcase
    end

    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_hold) |-> ($past(ack_bit) && !$past(lp_por)));
    // R8
    pin_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_STOP && lp_exit && wake_pin) |=> !sys_hold);
    // R13
    exit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_EXIT && !lp_por) |=> sys_hold);
endmodule

// File: rtl/drh_core_hold.sv
module drh_core_hold
    import drh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_done,
    input  logic hold_cfg,
    output logic core_hold
);
    ch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_SEQ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_SEQ: begin
                if (seq_done) state_d = hold_cfg ? CH_HELD : CH_RUN;
            end
            CH_RUN: begin
                if (!seq_done) state_d = CH_SEQ;
            end
            CH_HELD: begin
                if (!seq_done)     state_d = CH_SEQ;
                else if (!hold_cfg) state_d = CH_RUN;
            end
            default: state_d = CH_SEQ;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CH_HELD: core_hold = hold_cfg;
            default: core_hold = 1'b0;
        endcase
    end

    // R4
    core_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_hold) |-> ($past(seq_done) && $past(hold_cfg)));
endmodule

// File: rtl/dbg_rst_hold_ctrl.sv
module dbg_rst_hold_ctrl
    import drh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             secure,
    output logic [REG_W-1:0] rd_data,
    input  logic             seq_done,
    input  logic             lp_enter,
    input  logic             lp_exit,
    input  logic             wake_pin,
    input  logic             lp_por,
    output logic             halt_req,
    output logic             sys_rst_hold,
    output logic             core_rst_hold,
    output logic             stat_clr
);
    logic [REG_W-1:0] ctl_q;
    logic             seq_sys_hold;

    drh_ctl_reg #(.W(REG_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .secure   (secure),
        .lp_por   (lp_por),
        .ctl_q    (ctl_q),
        .stat_clr (stat_clr)
    );

    drh_lp_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_enter (lp_enter),
        .lp_exit  (lp_exit),
        .wake_pin (wake_pin),
        .lp_por   (lp_por),
        .arm_bit  (ctl_q[B_ARM]),
        .ack_bit  (ctl_q[B_ACK]),
        .sys_hold (seq_sys_hold)
    );

    drh_core_hold u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_done  (seq_done),
        .hold_cfg  (ctl_q[B_CHOLD]),
        .core_hold (core_rst_hold)
    );

    always_comb begin
        rd_data      = ctl_q;
        halt_req     = ctl_q[B_HALT];
        sys_rst_hold = ctl_q[B_SRST] | seq_sys_hold;
    end

    // R3
    sys_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_SRST] |-> sys_rst_hold);
    // R5
    core_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[B_CHOLD] |-> !core_rst_hold);
endmodule

// File: tb/sim_dbg_rst_hold_ctrl.sv
module sim_dbg_rst_hold_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        secure = 1'b0;
    logic [31:0] rd_data;
    logic        seq_done = 1'b1;
    logic        lp_enter = 1'b0;
    logic        lp_exit = 1'b0;
    logic        wake_pin = 1'b0;
    logic        lp_por = 1'b0;
    logic        halt_req, sys_rst_hold, core_rst_hold, stat_clr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_rst_hold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .secure(secure), .rd_data(rd_data), .seq_done(seq_done),
        .lp_enter(lp_enter), .lp_exit(lp_exit), .wake_pin(wake_pin),
        .lp_por(lp_por), .halt_req(halt_req), .sys_rst_hold(sys_rst_hold),
        .core_rst_hold(core_rst_hold), .stat_clr(stat_clr)
    );

    // {secure, write value, expected rd_data, expected halt_req, expected sys_rst_hold}
    localparam int NV = 7;
    localparam logic [66:0] VEC [0:NV-1] = '{
        {1'b0, 32'hFFFF_FFFF, 32'h0000_00FC, 1'b1, 1'b1},
        {1'b1, 32'h0000_0000, 32'h0000_00F4, 1'b1, 1'b0},
        {1'b1, 32'h0000_0008, 32'h0000_00FC, 1'b1, 1'b1},
        {1'b0, 32'h0000_0004, 32'h0000_0004, 1'b1, 1'b0},
        {1'b0, 32'hFFFF_FF03, 32'h0000_0000, 1'b0, 1'b0},
        {1'b0, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b1},
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d, input logic sec);
        wr_en = 1'b1; wr_data = d; secure = sec;
        @(negedge clk);
        wr_en = 1'b0; secure = 1'b0;
    endtask

    task automatic enter_pulse();
        lp_enter = 1'b1;
        @(negedge clk);
        lp_enter = 1'b0;
    endtask

    task automatic exit_pulse(input logic pin);
        lp_exit = 1'b1; wake_pin = pin;
        @(negedge clk);
        lp_exit = 1'b0; wake_pin = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outputs", {28'h0, halt_req, sys_rst_hold, core_rst_hold, stat_clr}, 32'h0);

        // R2 R3 R11 R12 register table
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][65:34], VEC[v][66]);
            chk($sformatf("R11/R12 vec%0d rd_data", v), rd_data, VEC[v][33:2]);
            chk($sformatf("R2 vec%0d halt_req", v), {31'h0, halt_req}, {31'h0, VEC[v][1]});
            chk($sformatf("R3 vec%0d sys_rst_hold", v), {31'h0, sys_rst_hold}, {31'h0, VEC[v][0]});
        end

        // R4 R5 core hold at end of sequencing
        seq_done = 1'b0;
        step(1);
        wr(32'h10, 1'b0);
        seq_done = 1'b1;
        step(1);
        chk("R4 core held", {31'h0, core_rst_hold}, 32'h1);
        step(2);
        chk("R4 core still held", {31'h0, core_rst_hold}, 32'h1);
        wr(32'h0, 1'b0);
        chk("R5 immediate release", {31'h0, core_rst_hold}, 32'h0);
        seq_done = 1'b0;
        step(1);
        seq_done = 1'b1;
        step(2);
        chk("R4 no hold when bit4 clear", {31'h0, core_rst_hold}, 32'h0);

        // R6 R7 R9 R13 armed exit with stale acknowledge
        wr(32'h20, 1'b0);
        enter_pulse();
        wr(32'h40, 1'b0);
        exit_pulse(1'b0);
        chk("R7 hold after exit", {31'h0, sys_rst_hold}, 32'h1);
        step(2);
        chk("R13 stale ack ignored", {31'h0, sys_rst_hold}, 32'h1);
        lp_por = 1'b1;
        step(1);
        chk("R9 por clears bits 5 6", rd_data & 32'h60, 32'h0);
        wr(32'h40, 1'b0);
        chk("R9 por beats write", rd_data & 32'h60, 32'h0);
        lp_por = 1'b0;
        step(3);
        chk("R7 hold after por", {31'h0, sys_rst_hold}, 32'h1);
        wr(32'h40, 1'b0);
        chk("R7 hold in first ack cycle", {31'h0, sys_rst_hold}, 32'h1);
        step(1);
        chk("R7 released after ack", {31'h0, sys_rst_hold}, 32'h0);

        // R6 arm bit set only after entry has no effect
        wr(32'h0, 1'b0);
        enter_pulse();
        wr(32'h20, 1'b0);
        exit_pulse(1'b0);
        step(1);
        chk("R6 late arm ignored", {31'h0, sys_rst_hold}, 32'h0);
        wr(32'h0, 1'b0);

        // R8 pin wake skips the hold
        wr(32'h20, 1'b0);
        enter_pulse();
        exit_pulse(1'b1);
        chk("R8 pin wake no hold", {31'h0, sys_rst_hold}, 32'h0);
        step(2);
        chk("R8 pin wake stays free", {31'h0, sys_rst_hold}, 32'h0);
        wr(32'h0, 1'b0);

        // R10 status clear pulse
        wr(32'h80, 1'b0);
        chk("R10 pulse high", {31'h0, stat_clr}, 32'h1);
        step(1);
        chk("R10 pulse one cycle", {31'h0, stat_clr}, 32'h0);
        wr(32'h80, 1'b0);
        chk("R10 no pulse when held", {31'h0, stat_clr}, 32'h0);
        wr(32'h0, 1'b0);
        wr(32'h80, 1'b0);
        chk("R10 pulse after re-arm", {31'h0, stat_clr}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule